// File: doc/BRIEF.md
# Receive Byte-to-Halfword Packer

This block sits between a receive MAC byte stream and a client that consumes data 16 bits at a time. Each accepted input byte is placed into a pair register. When the pair is complete, the block issues one halfword to the client. The first byte of a pair always lands in the low lane.

The end of each frame is marked on its final byte, together with a compliant/non-compliant status. A frame with an odd byte count ends in a halfword that holds only the lone byte in the low lane, and a dedicated flag marks that halfword. One clock after the final halfword, a single-cycle good or bad strobe reports the frame status. Nothing of the pair register survives from one frame into the next.

Top module: `rx_halfword_packer`

## Requirements
- R1: Within a frame, input byte 2k goes to `cl_data[7:0]` and byte 2k+1 goes to `cl_data[15:8]`. The halfword shows with `cl_vld` high in the cycle after the clock edge that accepted byte 2k+1.
- R2: `cl_vld` is high for exactly one cycle per completed halfword. A frame of N bytes produces exactly ceil(N/2) halfwords, and an unpaired non-final byte produces no output.
- R3: For a frame with an even byte count, `cl_odd` is low on every halfword, including the final one.
- R4: For a frame with an odd byte count, the final halfword carries the last byte in `cl_data[7:0]` and 8'h00 in `cl_data[15:8]`. `cl_odd` is high on that halfword only.
- R5: When the final byte arrives with `rx_ok` = 1, `cl_good` pulses high in the cycle right after the final halfword.
- R6: When the final byte arrives with `rx_ok` = 0, `cl_bad` pulses high in the cycle right after the final halfword.
- R7: `cl_good` and `cl_bad` each last one clock per frame and are never high together.
- R8: After a frame ends, the pair register is empty, so the next frame's first byte again goes to the low lane.
- R9: While `rst_n` is low at a rising edge, all outputs and the pairing state clear. This includes a half-filled pair from an interrupted frame.
- R10: `rx_byte`, `rx_eof` and `rx_ok` are ignored in cycles where `rx_vld` is low, so idle gaps between bytes leave the output stream unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_vld | input | 1 | Input byte valid |
| rx_byte | input | 8 | Input byte |
| rx_eof | input | 1 | Marks the final byte of a frame (qualified by rx_vld) |
| rx_ok | input | 1 | Frame status with rx_eof: 1 compliant, 0 non-compliant |
| cl_vld | output | 1 | Output halfword valid |
| cl_data | output | 16 | Output halfword, first byte in [7:0] |
| cl_odd | output | 1 | Final halfword holds only the low byte |
| cl_good | output | 1 | One-cycle pulse: frame was compliant |
| cl_bad | output | 1 | One-cycle pulse: frame was non-compliant |

## Verification
A pair register stuck in the half-full state shows up on the client port almost at once. Within one or two halfwords, the lanes appear swapped or a frame emits the wrong number of halfwords. That makes per-frame word counts and lane contents the main observable. An odd frame followed by another frame exposes a leftover byte on the very next halfword. Lost or misrouted status shows one cycle after the last halfword, as a missing, doubled, swapped or mistimed strobe. Each frame's strobe cycle is therefore compared against its final halfword's cycle.

// File: rtl/rxpk_pkg.sv
// Package: shared types for the receive halfword packer.
// Assumes: one byte lane per input beat, two lanes per output word.
package rxpk_pkg;
    typedef enum logic {
        PAIR_EMPTY = 1'b0,
        PAIR_HALF  = 1'b1
    } pair_st_e;

    localparam int LANES = 2;
endpackage

// File: rtl/rxpk_pair_lane.sv
// Module: rxpk_pair_lane
// Pairs accepted bytes into words. The first byte of a pair goes to the low lane.
// A final byte with no partner is emitted alone, with the high lane zeroed and
// word_odd set. Assumes byte_end is only meaningful when byte_vld is high.
module rxpk_pair_lane
    import rxpk_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_dat,
    input  logic              byte_end,
    output logic              word_vld,
    output logic [WORD_W-1:0] word_dat,
    output logic              word_odd
);
    pair_st_e          pair_st;
    logic [BYTE_W-1:0] lo_hold;

    // Pair-state tracking: fills on a non-final first byte, empties otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_st <= PAIR_EMPTY;
            lo_hold <= '0;
        end else if (byte_vld) begin
            if (pair_st == PAIR_EMPTY && !byte_end) begin
                pair_st <= PAIR_HALF;
                lo_hold <= byte_dat;
            end else begin
                pair_st <= PAIR_EMPTY;
            end
        end
    end

    // Output word register: emits a full pair or a lone final byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_vld <= 1'b0;
            word_dat <= '0;
            word_odd <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            word_odd <= 1'b0;
            if (byte_vld) begin
                if (pair_st == PAIR_HALF) begin
                    word_vld <= 1'b1;
                    word_dat <= {byte_dat, lo_hold};
                end else if (byte_end) begin
                    word_vld <= 1'b1;
                    word_dat <= {{BYTE_W{1'b0}}, byte_dat};
                    word_odd <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rxpk_status_delay.sv
// Module: rxpk_status_delay
// Turns the status seen with a frame's final byte into a one-cycle good or bad
// strobe, one clock after the final word leaves the pair lane.
// Assumes: end_seen pulses once per frame.
module rxpk_status_delay (
    input  logic clk,
    input  logic rst_n,
    input  logic end_seen,
    input  logic end_ok,
    output logic good_stb,
    output logic bad_stb
);
    logic pend_vld;
    logic pend_ok;

    // Stage one: hold the status alongside the final word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld <= 1'b0;
            pend_ok  <= 1'b0;
        end else begin
            pend_vld <= end_seen;
            pend_ok  <= end_ok;
        end
    end

    // Stage two: issue exactly one of the two strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good_stb <= 1'b0;
            bad_stb  <= 1'b0;
        end else begin
            good_stb <= pend_vld &&  pend_ok;
            bad_stb  <= pend_vld && !pend_ok;
        end
    end
endmodule

// File: rtl/rx_halfword_packer.sv
// Module: rx_halfword_packer (top)
// Receive byte stream to client halfword stream, with an odd-byte flag and
// frame status strobes. Assumes a single clock domain and CRC already judged.
module rx_halfword_packer #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = rxpk_pkg::LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_vld,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_eof,
    input  logic              rx_ok,
    output logic              cl_vld,
    output logic [WORD_W-1:0] cl_data,
    output logic              cl_odd,
    output logic              cl_good,
    output logic              cl_bad
);
    logic frame_end;

    // Frame end qualifier: the end mark only counts on a valid byte.
    always_comb frame_end = rx_vld && rx_eof;

    rxpk_pair_lane #(.BYTE_W(BYTE_W)) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_vld (rx_vld),
        .byte_dat (rx_byte),
        .byte_end (rx_eof),
        .word_vld (cl_vld),
        .word_dat (cl_data),
        .word_odd (cl_odd)
    );

    rxpk_status_delay u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .end_seen (frame_end),
        .end_ok   (rx_ok),
        .good_stb (cl_good),
        .bad_stb  (cl_bad)
    );
endmodule

// File: rtl/rx_halfword_packer_chk.sv
// Module: rx_halfword_packer_chk
// Port-level temporal checks for rx_halfword_packer, attached by bind.
module rx_halfword_packer_chk #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_vld,
    input logic              rx_eof,
    input logic              cl_vld,
    input logic [WORD_W-1:0] cl_data,
    input logic              cl_odd,
    input logic              cl_good,
    input logic              cl_bad
);
    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cl_good && cl_bad)); // R7
    AST_GOOD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cl_good |=> !cl_good); // R7
    AST_BAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cl_bad |=> !cl_bad); // R7
    AST_ODD_ONLY_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        cl_odd |-> cl_vld); // R4
    AST_ODD_HIGH_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_vld && cl_odd) |-> (cl_data[WORD_W-1:BYTE_W] == '0)); // R4
    AST_ODD_FROM_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld && !rx_eof) |=> !cl_odd); // R3
    AST_WORD_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        cl_vld |-> $past(rx_vld)); // R2
    AST_STATUS_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_good || cl_bad) |-> $past(cl_vld)); // R5
endmodule

bind rx_halfword_packer rx_halfword_packer_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_vld  (rx_vld),
    .rx_eof  (rx_eof),
    .cl_vld  (cl_vld),
    .cl_data (cl_data),
    .cl_odd  (cl_odd),
    .cl_good (cl_good),
    .cl_bad  (cl_bad)
);

// File: tb/rx_halfword_packer_tb.sv
module rx_halfword_packer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_vld = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_eof = 1'b0;
    logic        rx_ok = 1'b0;
    logic        cl_vld;
    logic [15:0] cl_data;
    logic        cl_odd;
    logic        cl_good;
    logic        cl_bad;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // Monitor logs
    logic [15:0] wlog [16];
    logic        olog [16];
    int nw = 0, ngood = 0, nbad = 0;
    int last_w_cyc = -1, stb_cyc = -1;
    int overlap = 0, stb_prev = 0, stb_run = 0;

    // Frame vectors: [15:12] length, [11] status ok, [10] idle gaps, [7:0] first byte
    localparam logic [15:0] VEC [7] = '{
        16'h2810, 16'h1820, 16'h5030, 16'h6C40, 16'h3C50, 16'h4060, 16'h1070
    };

    always #2.5 clk = ~clk;

    rx_halfword_packer u_dut (
        .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_byte(rx_byte),
        .rx_eof(rx_eof), .rx_ok(rx_ok), .cl_vld(cl_vld), .cl_data(cl_data),
        .cl_odd(cl_odd), .cl_good(cl_good), .cl_bad(cl_bad)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (cl_vld) begin
                if (nw < 16) begin
                    wlog[nw] = cl_data;
                    olog[nw] = cl_odd;
                end
                nw++;
                last_w_cyc = cyc;
            end
            if (cl_good) begin ngood++; stb_cyc = cyc; end
            if (cl_bad)  begin nbad++;  stb_cyc = cyc; end
            if (cl_good && cl_bad) overlap++;
            if ((cl_good || cl_bad) && stb_prev != 0) stb_run++;
            stb_prev = (cl_good || cl_bad) ? 1 : 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        @(posedge clk); #1;
        nw = 0; ngood = 0; nbad = 0; last_w_cyc = -1; stb_cyc = -1;
    endtask

    task automatic send_frame(input int len, input logic [7:0] base, input bit ok, input bit gap);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_vld = 1'b1; rx_byte = base + 8'(i);
            rx_eof = (i == len - 1); rx_ok = ok;
            if (gap && i != len - 1) begin
                @(negedge clk);
                rx_vld = 1'b0; rx_byte = 8'hFF; rx_eof = 1'b1; rx_ok = ~ok; // R10 junk
            end
        end
        @(negedge clk);
        rx_vld = 1'b0; rx_eof = 1'b0; rx_byte = 8'h00;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_frame(input int len, input logic [7:0] base, input bit ok);
        int exp_w;
        exp_w = (len + 1) / 2;
        check(nw == exp_w, "R2 word count", nw, exp_w);
        for (int k = 0; k < exp_w && k < 16; k++) begin
            logic [7:0] lo;
            logic [7:0] hi;
            bit odd;
            lo = base + 8'(2 * k);
            odd = (2 * k + 1 == len);
            hi = odd ? 8'h00 : base + 8'(2 * k + 1);
            check(wlog[k] == {hi, lo}, odd ? "R4 odd final word" : "R1 R8 lane order",
                  int'(wlog[k]), int'({hi, lo}));
            check(olog[k] == odd, (len % 2 == 1) ? "R4 odd flag" : "R3 even flag",
                  int'(olog[k]), int'(odd));
        end
        if (ok) check(ngood == 1 && nbad == 0, "R5 good strobe", ngood * 16 + nbad, 16);
        else    check(nbad == 1 && ngood == 0, "R6 bad strobe", ngood * 16 + nbad, 1);
        check(stb_cyc == last_w_cyc + 1, "R5 R6 strobe timing", stb_cyc, last_w_cyc + 1);
    endtask

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check(!cl_vld && cl_data == 16'h0 && !cl_odd && !cl_good && !cl_bad,
              "R9 reset outputs", int'({cl_vld, cl_odd, cl_good, cl_bad}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk
        for (int v = 0; v < 7; v++) begin
            clear_log();
            send_frame(int'(VEC[v][15:12]), VEC[v][7:0], VEC[v][11], VEC[v][10]);
            check_frame(int'(VEC[v][15:12]), VEC[v][7:0], VEC[v][11]);
        end

        // R10: idle junk with eof asserted but no valid produces nothing
        clear_log();
        @(negedge clk); rx_vld = 1'b0; rx_byte = 8'hAA; rx_eof = 1'b1; rx_ok = 1'b1;
        repeat (3) @(negedge clk);
        rx_eof = 1'b0;
        repeat (3) @(negedge clk);
        check(nw == 0 && ngood == 0 && nbad == 0, "R10 idle ignored", nw + ngood + nbad, 0);

        // R9: reset clears half-filled pair
        clear_log();
        @(negedge clk); rx_vld = 1'b1; rx_byte = 8'hEE; rx_eof = 1'b0;
        @(negedge clk); rx_vld = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check(!cl_vld && !cl_good && !cl_bad, "R9 reset mid-frame outputs", int'(cl_vld), 0);
        rst_n = 1'b1;
        clear_log();
        send_frame(2, 8'h90, 1'b1, 1'b0);
        check_frame(2, 8'h90, 1'b1);

        // R8: odd frame then back-to-back next frame
        clear_log();
        send_frame(3, 8'hA0, 1'b0, 1'b0);
        check_frame(3, 8'hA0, 1'b0);
        clear_log();
        send_frame(4, 8'hB0, 1'b1, 1'b0);
        check_frame(4, 8'hB0, 1'b1);

        // R7 strobe shape across the run
        check(overlap == 0, "R7 strobes together", overlap, 0);
        check(stb_run == 0, "R7 strobe width", stb_run, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule